// File: doc/BRIEF.md
# Configuration Variable Readback Engine

This engine recovers the value of one decoder configuration variable. The decoder cannot return data. For each query it either acknowledges or stays silent. The engine therefore builds the value from a series of yes/no questions. Packet framing and acknowledge detection are handled by neighbouring logic. The engine only issues the questions and interprets the answers.

Two search strategies are selectable at start:

- **Bit mode** asks, for each bit position from 0 up to 7, whether that bit is 1. A full byte is known after exactly 8 queries.
- **Byte mode** asks whether the whole variable equals a candidate value. The candidate counts up from 0 until one is acknowledged. If the candidate reaches 255 without any acknowledge, the engine reports 255 (the last candidate tried) and raises a failure flag.

Only one query is in flight at a time. A query is offered with a valid/ready handshake and answered with a response strobe carrying ack or no-ack.

Top module: `cv_readback`

## Requirements
- R1: After reset, q_valid, done, fail and busy are 0 and result is 0x00.
- R2: In bit mode (byte_mode=0 at start), the engine issues exactly 8 queries. They have q_byte=0, q_bit counting 0,1,…,7 and q_data=0x01 (the question "is bit q_bit equal to 1").
- R3: In bit mode, an acknowledge to the query for bit i sets result bit i, and a non-acknowledge clears it. done pulses for one cycle after the eighth response, and fail stays 0.
- R4: In byte mode (byte_mode=1 at start), queries have q_byte=1, q_bit=0 and q_data equal to the candidate, which starts at 0 and increases by 1 per query.
- R5: In byte mode, done is 1 in the cycle after the first acknowledged response, with result equal to that query's candidate and fail=0. No further query is issued.
- R6: In byte mode, if the candidate 255 is answered with no acknowledge, done pulses with result=0xFF and fail=1, after 256 queries in total.
- R7: At most one query is outstanding. While q_valid=1 and q_ready=0, q_valid and all q_* fields stay stable. After the handshake, q_valid stays 0 until a response strobe arrives.
- R8: A start pulse while busy=1 is ignored: the running search keeps its variable number, mode and progress.
- R9: result and fail hold their values after done until the next accepted start. An accepted start clears fail.
- R10: q_cv equals the cv_num value captured by the accepted start, for every query of that search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| byte_mode | input | 1 | 0 = bit mode, 1 = byte mode, captured at start |
| cv_num | input | 10 | Variable number, captured at start |
| q_valid | output | 1 | Query request valid |
| q_ready | input | 1 | Query accepted by the packet side |
| q_cv | output | 10 | Variable number of the query |
| q_byte | output | 1 | 1 = whole-byte compare, 0 = single-bit compare |
| q_bit | output | 3 | Bit index asked (bit mode) |
| q_data | output | 8 | Candidate byte (byte mode) or expected bit value 1 (bit mode) |
| rsp_valid | input | 1 | Response strobe for the outstanding query |
| rsp_ack | input | 1 | 1 = decoder acknowledged |
| result | output | 8 | Assembled variable value |
| done | output | 1 | One-cycle pulse when a search ends |
| fail | output | 1 | Byte search ended without acknowledge |
| busy | output | 1 | Search in progress |

## Verification
The engine reacts at set delays. q_valid rises in the cycle after an accepted start and falls in the cycle after the handshake. The next q_valid, or done, appears in the cycle after the response strobe. The bench drives inputs on falling edges and checks outputs at the next falling edge, exactly one register stage after the stimulus. The bench responder holds q_ready low and delays responses for varying numbers of cycles. It checks during these delays that the request stays stable and that no second query appears.

// File: rtl/cv_readback.sv
module cv_readback #(
  parameter int CV_W = 10,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              byte_mode,
  input  logic [CV_W-1:0]   cv_num,
  output logic              q_valid,
  input  logic              q_ready,
  output logic [CV_W-1:0]   q_cv,
  output logic              q_byte,
  output logic [IDX_W-1:0]  q_bit,
  output logic [DATA_W-1:0] q_data,
  input  logic              rsp_valid,
  input  logic              rsp_ack,
  output logic [DATA_W-1:0] result,
  output logic              done,
  output logic              fail,
  output logic              busy
);
  localparam logic [IDX_W-1:0]  LAST_BIT = IDX_W'(DATA_W - 1);
  localparam logic [DATA_W-1:0] LAST_CAND = '1;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} state_t;
  state_t state;

  logic [CV_W-1:0]   cv_q;
  logic              mode_q;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] cand;

  wire got = (state == S_WAIT) && rsp_valid;

  assign busy    = (state != S_IDLE);
  assign q_valid = (state == S_REQ);
  assign q_cv    = cv_q;
  assign q_byte  = mode_q;
  assign q_bit   = mode_q ? '0 : idx;
  assign q_data  = mode_q ? cand : DATA_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cv_q   <= '0;
      mode_q <= 1'b0;
      idx    <= '0;
      cand   <= '0;
      result <= '0;
      done   <= 1'b0;
      fail   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state  <= S_REQ;
          cv_q   <= cv_num;
          mode_q <= byte_mode;
          idx    <= '0;
          cand   <= '0;
          result <= '0;
          fail   <= 1'b0;
        end
        S_REQ: if (q_ready) state <= S_WAIT;
        S_WAIT: if (got) begin
          if (!mode_q) begin
            result[idx] <= rsp_ack;
            if (idx == LAST_BIT) begin
              state <= S_IDLE;
              done  <= 1'b1;
            end else begin
              idx   <= idx + 1'b1;
              state <= S_REQ;
            end
          end else if (rsp_ack) begin
            result <= cand;
            done   <= 1'b1;
            state  <= S_IDLE;
          end else if (cand == LAST_CAND) begin
            result <= LAST_CAND;
            fail   <= 1'b1;
            done   <= 1'b1;
            state  <= S_IDLE;
          end else begin
            cand  <= cand + 1'b1;
            state <= S_REQ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid && !q_ready |=> q_valid && $stable(q_cv) && $stable(q_data) && $stable(q_bit) && $stable(q_byte));
  // R7
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid && q_ready |=> !q_valid);
  // R5
  byte_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    got && mode_q && rsp_ack |=> done && !fail && !q_valid && result == $past(q_data));
  // R6
  fail_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> result == LAST_CAND);
  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(result) && $stable(fail));
endmodule

// File: tb/test_cv_readback.sv
module test_cv_readback;
  logic clk = 0, rst_n = 0, start = 0, byte_mode = 0, q_ready = 0, rsp_valid = 0, rsp_ack = 0;
  logic [9:0] cv_num = '0;
  logic q_valid, q_byte, done, fail, busy;
  logic [9:0] q_cv;
  logic [2:0] q_bit;
  logic [7:0] q_data, result;
  int checks = 0, failures = 0, cycles = 0;
  logic [9:0] exp_cv;
  bit poke = 0;

  cv_readback i_cv_readback (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic kick(input logic [9:0] cv, input logic bm);
    @(negedge clk);
    start = 1; cv_num = cv; byte_mode = bm; exp_cv = cv;
    @(negedge clk);
    start = 0;
    chk(q_valid == 1 && busy == 1, "R10 start", q_valid, 1);
  endtask

  // serves queries; ack for bit mode = tgt[bit], byte mode = (candidate==tgt) unless nohit
  task automatic serve(input logic [7:0] tgt, input logic bm, input bit nohit, input int lat, output int nq);
    logic [7:0] qd; logic [2:0] qb; bit ok;
    nq = 0;
    while (nq < 300) begin
      while (!q_valid) @(negedge clk);
      qd = q_data; qb = q_bit;
      ok = (q_cv == exp_cv) && (q_byte == bm) &&
           (bm ? (qd == 8'(nq) && qb == 0) : (qd == 8'h01 && qb == 3'(nq)));
      if (bm) chk(ok, "R4 R10 query fields", qd, nq);
      else    chk(ok, "R2 R10 query fields", qb, nq);
      for (int k = 0; k < lat; k++) begin
        @(negedge clk);
        chk(q_valid && q_data == qd && q_bit == qb && q_cv == exp_cv, "R7 hold", q_data, qd);
      end
      q_ready = 1;
      @(negedge clk);
      q_ready = 0;
      nq++;
      chk(!q_valid, "R7 single outstanding", q_valid, 0);
      for (int k = 0; k < lat; k++) begin
        if (poke && nq == 2 && k == 0) begin
          start = 1; cv_num = ~exp_cv; byte_mode = ~bm;
        end
        @(negedge clk);
        start = 0;
        chk(!q_valid && !done, "R7 R8 no new query", q_valid, 0);
      end
      rsp_valid = 1;
      rsp_ack = nohit ? 1'b0 : (bm ? (qd == tgt) : tgt[qb]);
      @(negedge clk);
      rsp_valid = 0; rsp_ack = 0;
      if (done) break;
    end
  endtask

  task automatic reset_test;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(!q_valid && !done && !fail && !busy && result == 0, "R1 reset", result, 0);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic bit_test(input logic [9:0] cv, input logic [7:0] v, input int lat);
    int nq;
    kick(cv, 0);
    serve(v, 0, 0, lat, nq);
    chk(nq == 8, "R2 query count", nq, 8);
    chk(done && result == v && !fail, "R3 bit result", result, v);
    @(negedge clk);
    chk(!done && !busy, "R3 done pulse", done, 0);
    repeat (4) @(negedge clk);
    chk(result == v, "R9 hold", result, v);
  endtask

  task automatic byte_test(input logic [9:0] cv, input logic [7:0] v, input int lat);
    int nq;
    kick(cv, 1);
    serve(v, 1, 0, lat, nq);
    chk(nq == int'(v) + 1, "R5 query count", nq, int'(v) + 1);
    chk(done && result == v && !fail, "R5 byte result", result, v);
    @(negedge clk);
    chk(!q_valid && !busy, "R5 stop", q_valid, 0);
  endtask

  task automatic byte_miss_test;
    int nq;
    kick(10'h3FF, 1);
    serve(8'h00, 1, 1, 0, nq);
    chk(nq == 256, "R6 query count", nq, 256);
    chk(done && fail && result == 8'hFF, "R6 fail result", result, 255);
    repeat (3) @(negedge clk);
    chk(fail && result == 8'hFF, "R9 fail holds", fail, 1);
    kick(10'd5, 0);
    chk(!fail, "R9 start clears fail", fail, 0);
    serve(8'h3C, 0, 0, 0, nq);
    chk(result == 8'h3C && !fail, "R3 after fail", result, 8'h3C);
  endtask

  task automatic busy_start_test;
    int nq;
    poke = 1;
    kick(10'd300, 0);
    serve(8'hA5, 0, 0, 2, nq);
    poke = 0;
    chk(nq == 8 && result == 8'hA5, "R8 start ignored", result, 8'hA5);
  endtask

  initial begin
    reset_test();
    bit_test(10'd1, 8'h00, 0);
    bit_test(10'd1023, 8'hFF, 1);
    bit_test(10'd512, 8'h96, 3);
    byte_test(10'd29, 8'h00, 0);
    byte_test(10'd8, 8'h20, 2);
    byte_test(10'd700, 8'hFF, 0);
    byte_miss_test();
    busy_start_test();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule